// File: doc/BRIEF.md
# Two-Direction Stream Data Prefetcher

This block watches the demand loads that reach a second-level cache, one line address per cycle, and learns sequential streams from them. Rising streams live in a sixteen-entry table and falling streams in a four-entry table. Every load either lands on a tracked stream or opens a new one. A stream counts as confirmed on the second load that belongs to it. From that load on, each demand load of the stream asks for the following line in the stream's direction, so the line is in the second-level cache before the first-level cache misses on it.

A new stream always starts in the rising table as an unconfirmed entry. If the second load of that stream is one line below the first, the entry moves into the falling table, already confirmed. Each table replaces its least recently used entry. An age counter per entry tracks recency, and the age list stays a permutation at all times.

Prefetch requests leave through a registered valid/line output with a ready input. A request is held while ready is low. A trigger that arrives while a request is stalled is discarded, not queued. The output is a two-state machine. `PF_IDLE` moves to `PF_OFFER` on a trigger. `PF_OFFER` stays in `PF_OFFER` while ready is low, or when a new trigger is accepted together with ready. `PF_OFFER` returns to `PF_IDLE` when ready is high and no trigger arrives. Each load is classified into one action: `ACT_NONE`, `ACT_RISE_STEP`, `ACT_RISE_REPEAT`, `ACT_FALL_STEP`, `ACT_TURN` or `ACT_NEW`.

Top module: `stream_prefetcher`

## Requirements
- R1: A synchronous reset empties both tables and drives `pf_valid` low. A stream that was confirmed before the reset does not prefetch on its next line afterwards.
- R2: A load whose line matches no tracked stream issues no prefetch. It is recorded as a new unconfirmed entry in the rising table.
- R3: A load at line L+1, where L is the line of an unconfirmed rising entry, issues a prefetch of line L+2 in the same clock edge that samples the load. With ready high and no new trigger, `pf_valid` falls on the next edge.
- R4: After a rising stream issues a prefetch of line P, a demand load of line P issues a prefetch of line P+1, and so on one line ahead.
- R5: Repeating the line of an unconfirmed rising entry issues no prefetch and keeps that entry. The next line after it still confirms the stream.
- R6: A load at line L-1, where L is the line of an unconfirmed rising entry, issues a prefetch of L-2 and moves the stream into the falling table. A demand load of each prefetched line P then issues a prefetch of P-1.
- R7: When all 16 rising entries are in use, a new stream replaces the least recently used one. A repeat load counts as a use.
- R8: When all 4 falling entries are in use, a fifth falling stream replaces the least recently used one. The streams that remain keep prefetching.
- R9: While `pf_ready` is low, `pf_valid` and `pf_line` hold. A trigger during the stall is dropped, but its stream still advances. The next demand load of that stream prefetches past the dropped line.
- R10: When one load both continues a rising stream and falls one line below another unconfirmed rising entry, the rising continuation wins and the prefetch is the line above.
- R11: Line arithmetic wraps modulo 2^LINE_W: a load of line 0 after the all-ones line confirms a rising stream and prefetches line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | A demand load is present this cycle |
| ld_line | input | LINE_W | Cache line address of the demand load (64-byte lines) |
| pf_ready | input | 1 | Downstream accepts the prefetch on offer |
| pf_valid | output | 1 | A prefetch request is on offer |
| pf_line | output | LINE_W | Line address to prefetch |

## Verification
Every result is due on the rising edge that samples the triggering load. A prefetch appears on `pf_valid`/`pf_line` at that edge, and an accepted request drops one edge later. The bench drives loads and ready on falling edges and reads the outputs on the next falling edge, half a cycle after the edge that produced them. A queue-based reference, ordered by recency, computes the same output for every cycle and is compared on each falling edge. Fixed expected line numbers at each step of the stream, stall, replacement and wrap scenarios back it up.

// File: rtl/stream_pf_pkg.sv
package stream_pf_pkg;

    typedef enum logic {
        PF_IDLE  = 1'b0,
        PF_OFFER = 1'b1
    } pf_state_e;

    typedef enum logic [2:0] {
        ACT_NONE        = 3'd0,
        ACT_RISE_STEP   = 3'd1,
        ACT_RISE_REPEAT = 3'd2,
        ACT_FALL_STEP   = 3'd3,
        ACT_TURN        = 3'd4,
        ACT_NEW         = 3'd5
    } pf_act_e;

endpackage

// File: rtl/stream_track_table.sv
module stream_track_table #(
    parameter int  ENTRIES = 16,
    parameter int  LINE_W  = 26,
    parameter bit  RISING  = 1'b1,
    localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] look_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic              wr_conf,
    input  logic [LINE_W-1:0] wr_last,
    input  logic              wr_touch,
    output logic              step_hit,
    output logic [IDX_W-1:0]  step_idx,
    output logic              rep_hit,
    output logic [IDX_W-1:0]  rep_idx,
    output logic              turn_hit,
    output logic [IDX_W-1:0]  turn_idx,
    output logic [IDX_W-1:0]  victim_idx
);

    localparam logic [IDX_W-1:0] AGE_OLDEST = IDX_W'(ENTRIES - 1);

    logic [ENTRIES-1:0] ent_v;
    logic [ENTRIES-1:0] ent_c;
    logic [LINE_W-1:0]  ent_last [ENTRIES];
    logic [IDX_W-1:0]   ent_age  [ENTRIES];

    logic [ENTRIES-1:0] step_vec;
    logic [ENTRIES-1:0] rep_vec;
    logic [ENTRIES-1:0] turn_vec;

    // Per-entry comparators; the direction picks which neighbour is "ahead".
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        logic [LINE_W-1:0] ahead;
        logic [LINE_W-1:0] behind;
        if (RISING) begin : g_up
            assign ahead  = ent_last[g] + LINE_W'(1);
            assign behind = ent_last[g] - LINE_W'(1);
        end else begin : g_dn
            assign ahead  = ent_last[g] - LINE_W'(1);
            assign behind = ent_last[g] + LINE_W'(1);
        end
        assign step_vec[g] = ent_v[g] &&
                             (ent_c[g] ? (look_line == ent_last[g]) : (look_line == ahead));
        assign rep_vec[g]  = ent_v[g] && !ent_c[g] && (look_line == ent_last[g]);
        assign turn_vec[g] = ent_v[g] && !ent_c[g] && (look_line == behind);
    end

    function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] vec);
        logic [IDX_W-1:0] pick;
        pick = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (vec[i]) pick = IDX_W'(i);
        end
        return pick;
    endfunction

    assign step_hit = |step_vec;
    assign step_idx = lowest_set(step_vec);
    assign rep_hit  = |rep_vec;
    assign rep_idx  = lowest_set(rep_vec);
    assign turn_hit = |turn_vec;
    assign turn_idx = lowest_set(turn_vec);

    // Free slot first, otherwise the oldest entry.
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (ent_age[i] == AGE_OLDEST) victim_idx = IDX_W'(i);
        end
        if (!(&ent_v)) victim_idx = lowest_set(~ent_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_v <= '0;
            ent_c <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                ent_age[i]  <= IDX_W'(i);
                ent_last[i] <= '0;
            end
        end else if (wr_en) begin
            ent_v[wr_idx]    <= wr_valid;
            ent_c[wr_idx]    <= wr_conf;
            ent_last[wr_idx] <= wr_last;
            if (wr_touch) begin
                for (int i = 0; i < ENTRIES; i++) begin
                    if (IDX_W'(i) == wr_idx)
                        ent_age[i] <= '0;
                    else if (ent_age[i] < ent_age[wr_idx])
                        ent_age[i] <= ent_age[i] + IDX_W'(1);
                end
            end
        end
    end

    // Recency list must stay a permutation of 0..ENTRIES-1 (R7, R8).
    logic [ENTRIES-1:0] age_seen;
    always_comb begin
        age_seen = '0;
        for (int i = 0; i < ENTRIES; i++) age_seen[ent_age[i]] = 1'b1;
    end

    p_age_perm_r7: assert property (@(posedge clk) disable iff (rst) &age_seen);

    // A just-used valid entry is never the next replacement choice (R7, R8).
    p_touched_kept_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_touch && wr_valid) |=> (victim_idx != $past(wr_idx)));

endmodule

// File: rtl/pf_issue.sv
module pf_issue
    import stream_pf_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [LINE_W-1:0] trig_line,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);

    pf_state_e state;
    pf_state_e state_nx;
    logic      take;

    always_ff @(posedge clk) begin
        if (rst) state <= PF_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PF_IDLE:  if (trig) state_nx = PF_OFFER;
            PF_OFFER: if (pf_ready && !trig) state_nx = PF_IDLE;
            default:  state_nx = PF_IDLE;
        endcase
    end

    assign take     = trig && ((state == PF_IDLE) || pf_ready);
    assign pf_valid = (state == PF_OFFER);

    always_ff @(posedge clk) begin
        if (rst)       pf_line <= '0;
        else if (take) pf_line <= trig_line;
    end

    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_line)));

    p_drain_r3: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && pf_ready && !trig) |=> !pf_valid);

endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import stream_pf_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int RISE_N = 16,
    parameter int FALL_N = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic [LINE_W-1:0] ld_line,
    input  logic              pf_ready,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line
);

    localparam int RI_W = (RISE_N > 1) ? $clog2(RISE_N) : 1;
    localparam int FI_W = (FALL_N > 1) ? $clog2(FALL_N) : 1;

    logic              r_step_hit, r_rep_hit, r_turn_hit;
    logic [RI_W-1:0]   r_step_idx, r_rep_idx, r_turn_idx, r_victim;
    logic              f_step_hit, f_rep_hit, f_turn_hit;
    logic [FI_W-1:0]   f_step_idx, f_rep_idx, f_turn_idx, f_victim;

    logic              r_wr_en, r_wr_valid, r_wr_conf, r_wr_touch;
    logic [RI_W-1:0]   r_wr_idx;
    logic [LINE_W-1:0] r_wr_last;
    logic              f_wr_en, f_wr_valid, f_wr_conf, f_wr_touch;
    logic [FI_W-1:0]   f_wr_idx;
    logic [LINE_W-1:0] f_wr_last;

    logic              trig;
    logic [LINE_W-1:0] trig_line;
    logic [LINE_W-1:0] line_up;
    logic [LINE_W-1:0] line_dn;
    pf_act_e           act;

    assign line_up = ld_line + LINE_W'(1);
    assign line_dn = ld_line - LINE_W'(1);

    stream_track_table #(.ENTRIES(RISE_N), .LINE_W(LINE_W), .RISING(1'b1)) u_rise (
        .clk        (clk),
        .rst        (rst),
        .look_line  (ld_line),
        .wr_en      (r_wr_en),
        .wr_idx     (r_wr_idx),
        .wr_valid   (r_wr_valid),
        .wr_conf    (r_wr_conf),
        .wr_last    (r_wr_last),
        .wr_touch   (r_wr_touch),
        .step_hit   (r_step_hit),
        .step_idx   (r_step_idx),
        .rep_hit    (r_rep_hit),
        .rep_idx    (r_rep_idx),
        .turn_hit   (r_turn_hit),
        .turn_idx   (r_turn_idx),
        .victim_idx (r_victim)
    );

    stream_track_table #(.ENTRIES(FALL_N), .LINE_W(LINE_W), .RISING(1'b0)) u_fall (
        .clk        (clk),
        .rst        (rst),
        .look_line  (ld_line),
        .wr_en      (f_wr_en),
        .wr_idx     (f_wr_idx),
        .wr_valid   (f_wr_valid),
        .wr_conf    (f_wr_conf),
        .wr_last    (f_wr_last),
        .wr_touch   (f_wr_touch),
        .step_hit   (f_step_hit),
        .step_idx   (f_step_idx),
        .rep_hit    (f_rep_hit),
        .rep_idx    (f_rep_idx),
        .turn_hit   (f_turn_hit),
        .turn_idx   (f_turn_idx),
        .victim_idx (f_victim)
    );

    // Classification priority: rising continuation, rising repeat,
    // falling continuation, turn into the falling table, new stream.
    always_comb begin
        act = ACT_NONE;
        if (ld_valid) begin
            if (r_step_hit)      act = ACT_RISE_STEP;
            else if (r_rep_hit)  act = ACT_RISE_REPEAT;
            else if (f_step_hit) act = ACT_FALL_STEP;
            else if (r_turn_hit) act = ACT_TURN;
            else                 act = ACT_NEW;
        end
    end

    always_comb begin
        r_wr_en = 1'b0; r_wr_idx = '0; r_wr_valid = 1'b0;
        r_wr_conf = 1'b0; r_wr_last = ld_line; r_wr_touch = 1'b0;
        f_wr_en = 1'b0; f_wr_idx = '0; f_wr_valid = 1'b0;
        f_wr_conf = 1'b0; f_wr_last = ld_line; f_wr_touch = 1'b0;
        trig = 1'b0; trig_line = ld_line;
        unique case (act)
            ACT_NONE: begin
            end
            ACT_RISE_STEP: begin
                r_wr_en = 1'b1; r_wr_idx = r_step_idx; r_wr_valid = 1'b1;
                r_wr_conf = 1'b1; r_wr_last = line_up; r_wr_touch = 1'b1;
                trig = 1'b1; trig_line = line_up;
            end
            ACT_RISE_REPEAT: begin
                r_wr_en = 1'b1; r_wr_idx = r_rep_idx; r_wr_valid = 1'b1;
                r_wr_conf = 1'b0; r_wr_last = ld_line; r_wr_touch = 1'b1;
            end
            ACT_FALL_STEP: begin
                f_wr_en = 1'b1; f_wr_idx = f_step_idx; f_wr_valid = 1'b1;
                f_wr_conf = 1'b1; f_wr_last = line_dn; f_wr_touch = 1'b1;
                trig = 1'b1; trig_line = line_dn;
            end
            ACT_TURN: begin
                r_wr_en = 1'b1; r_wr_idx = r_turn_idx; r_wr_valid = 1'b0;
                f_wr_en = 1'b1; f_wr_idx = f_victim; f_wr_valid = 1'b1;
                f_wr_conf = 1'b1; f_wr_last = line_dn; f_wr_touch = 1'b1;
                trig = 1'b1; trig_line = line_dn;
            end
            ACT_NEW: begin
                r_wr_en = 1'b1; r_wr_idx = r_victim; r_wr_valid = 1'b1;
                r_wr_conf = 1'b0; r_wr_last = ld_line; r_wr_touch = 1'b1;
            end
            default: begin
            end
        endcase
    end

    pf_issue #(.LINE_W(LINE_W)) u_issue (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .trig_line (trig_line),
        .pf_ready  (pf_ready),
        .pf_valid  (pf_valid),
        .pf_line   (pf_line)
    );

    // A fresh request is always caused by a load in the previous cycle (R3).
    p_pf_origin_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_valid) |-> $past(ld_valid));

    // A fresh request is always a neighbour of the load that caused it (R3, R6).
    p_pf_adjacent_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(pf_valid) |-> ((pf_line == $past(ld_line) + LINE_W'(1)) ||
                             (pf_line == $past(ld_line) - LINE_W'(1))));

    // The falling table only ever holds confirmed streams (R6).
    p_fall_confirmed_r6: assert property (@(posedge clk) disable iff (rst)
        !(f_turn_hit || f_rep_hit));

endmodule

// File: tb/sim_stream_prefetcher.sv
module sim_stream_prefetcher;

    localparam int          LW    = 26;
    localparam int unsigned LMASK = (32'd1 << LW) - 32'd1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_valid = 1'b0;
    logic [LW-1:0] ld_line = '0;
    logic          pf_ready = 1'b1;
    logic          pf_valid;
    logic [LW-1:0] pf_line;

    int    errors = 0;
    int    checks = 0;
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    stream_prefetcher #(.LINE_W(LW), .RISE_N(16), .FALL_N(4)) u0 (
        .clk      (clk),
        .rst      (rst),
        .ld_valid (ld_valid),
        .ld_line  (ld_line),
        .pf_ready (pf_ready),
        .pf_valid (pf_valid),
        .pf_line  (pf_line)
    );

    // Reference: recency-ordered queues, front = most recently used.
    typedef struct {
        int unsigned line;
        bit          conf;
    } trk_t;

    trk_t        rq[$];
    trk_t        fq[$];
    bit          m_v;
    int unsigned m_line;

    function automatic void model_load(input int unsigned l, output bit t,
                                       output int unsigned tl);
        int unsigned nx;
        int unsigned pv;
        trk_t        e;
        int          k;
        nx = (l + 1) & LMASK;
        pv = (l - 1) & LMASK;
        t  = 1'b0;
        tl = 0;
        k = -1;
        foreach (rq[i]) if (k < 0 && ((rq[i].conf && rq[i].line == l) ||
                 (!rq[i].conf && ((rq[i].line + 1) & LMASK) == l))) k = i;
        if (k >= 0) begin
            e = rq[k]; rq.delete(k); e.line = nx; e.conf = 1'b1;
            rq.push_front(e); t = 1'b1; tl = nx; return;
        end
        foreach (rq[i]) if (k < 0 && !rq[i].conf && rq[i].line == l) k = i;
        if (k >= 0) begin
            e = rq[k]; rq.delete(k); rq.push_front(e); return;
        end
        foreach (fq[i]) if (k < 0 && fq[i].conf && fq[i].line == l) k = i;
        if (k >= 0) begin
            e = fq[k]; fq.delete(k); e.line = pv; fq.push_front(e);
            t = 1'b1; tl = pv; return;
        end
        foreach (rq[i]) if (k < 0 && !rq[i].conf && ((rq[i].line - 1) & LMASK) == l) k = i;
        if (k >= 0) begin
            rq.delete(k); e.line = pv; e.conf = 1'b1; fq.push_front(e);
            if (fq.size() > 4) void'(fq.pop_back());
            t = 1'b1; tl = pv; return;
        end
        e.line = l; e.conf = 1'b0; rq.push_front(e);
        if (rq.size() > 16) void'(rq.pop_back());
    endfunction

    always @(posedge clk) begin
        bit          t;
        int unsigned tl;
        if (rst) begin
            rq.delete(); fq.delete(); m_v = 1'b0; m_line = 0;
        end else begin
            t = 1'b0; tl = 0;
            if (ld_valid) model_load(int'(ld_line), t, tl);
            if (t && (!m_v || pf_ready)) begin
                m_v = 1'b1; m_line = tl;
            end else if (m_v && pf_ready) begin
                m_v = 1'b0;
            end
        end
    end

    // Cycle-by-cycle comparison against the reference.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            checks++;
            if (pf_valid !== m_v || (m_v && pf_line !== LW'(m_line))) begin
                errors++;
                $display("FAIL %s per-cycle: actual v=%0b line=%0d expected v=%0b line=%0d",
                         cur_req, pf_valid, pf_line, m_v, m_line);
            end
        end
    end

    task automatic cyc(input bit v, input int unsigned l);
        ld_valid = v;
        ld_line  = LW'(l);
        @(negedge clk);
    endtask

    task automatic load(input int unsigned l);
        cyc(1'b1, l);
    endtask

    task automatic expect_pf(input string req, input bit v, input int unsigned l);
        cur_req = req;
        checks++;
        if (pf_valid !== v || (v && pf_line !== LW'(l))) begin
            errors++;
            $display("FAIL %s: actual v=%0b line=%0d expected v=%0b line=%0d",
                     req, pf_valid, pf_line, v, l);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        ld_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        expect_pf("R1", 1'b0, 0);

        // R2 new streams stay quiet; R3 second load confirms.
        load(1000);  expect_pf("R2", 1'b0, 0);
        load(2000);  expect_pf("R2", 1'b0, 0);
        load(1001);  expect_pf("R3", 1'b1, 1002);
        cyc(0, 0);   expect_pf("R3", 1'b0, 0);
        // R4 continuing stream stays one line ahead.
        load(1002);  expect_pf("R4", 1'b1, 1003);
        load(1003);  expect_pf("R4", 1'b1, 1004);
        // R5 repeat does not prefetch, entry kept.
        load(2000);  expect_pf("R5", 1'b0, 0);
        load(2001);  expect_pf("R5", 1'b1, 2002);
        // R6 falling stream.
        load(3000);  expect_pf("R6", 1'b0, 0);
        load(2999);  expect_pf("R6", 1'b1, 2998);
        load(2998);  expect_pf("R6", 1'b1, 2997);
        load(2997);  expect_pf("R6", 1'b1, 2996);
        // R10 rising continuation beats a turn.
        load(500);   expect_pf("R10", 1'b0, 0);
        load(502);   expect_pf("R10", 1'b0, 0);
        load(501);   expect_pf("R10", 1'b1, 502);
        // R11 wrap of line arithmetic.
        load(LMASK); expect_pf("R11", 1'b0, 0);
        load(0);     expect_pf("R11", 1'b1, 1);
        cyc(0, 0);
        // R9 backpressure: hold, drop, stream still advances.
        load(4000);  expect_pf("R9", 1'b0, 0);
        pf_ready = 1'b0;
        load(4001);  expect_pf("R9", 1'b1, 4002);
        cyc(0, 0);   expect_pf("R9", 1'b1, 4002);
        load(4002);  expect_pf("R9", 1'b1, 4002);
        pf_ready = 1'b1;
        cyc(0, 0);   expect_pf("R9", 1'b0, 0);
        load(4003);  expect_pf("R9", 1'b1, 4004);
        cyc(0, 0);

        // R7 rising table replacement.
        do_reset();
        expect_pf("R1", 1'b0, 0);
        for (int k = 0; k < 16; k++) begin
            load(10000 + 100 * k);
            expect_pf("R7", 1'b0, 0);
        end
        load(10000); expect_pf("R7", 1'b0, 0);
        load(20000); expect_pf("R7", 1'b0, 0);
        load(10101); expect_pf("R7", 1'b0, 0);
        load(10001); expect_pf("R7", 1'b1, 10002);
        cyc(0, 0);

        // R1 reset forgets confirmed streams; R8 falling table replacement.
        do_reset();
        load(10002); expect_pf("R1", 1'b0, 0);
        for (int k = 0; k < 5; k++) begin
            load(30000 + 100 * k);     expect_pf("R8", 1'b0, 0);
            load(30000 + 100 * k - 1); expect_pf("R8", 1'b1, 30000 + 100 * k - 2);
        end
        cyc(0, 0);
        load(30398); expect_pf("R8", 1'b1, 30397);
        load(29998); expect_pf("R8", 1'b0, 0);
        load(30098); expect_pf("R8", 1'b1, 30097);
        cyc(0, 0);
        cyc(0, 0);

        finish_run();
    end

endmodule